// File: doc/BRIEF.md
# Soft-Start and Fault Supervisor

This block decides when a PWM core may drive its power switches and how much duty it may use while it starts. It takes three digitized analog readings (supply, internal reference and switch current) and an error code from the control loop. From them it produces a drive-enable flag and a clamped error code for the PWM core.

Each supply reading passes through an under-voltage lockout with hysteresis, so it releases at a higher code than the one at which it trips again. Any active lockout, or a switch-current reading above a shutdown threshold, sets a restart latch. The set input wins over the clear input. While the latch is set, a digital soft-start level is pulled down on each rate tick. While it is clear, the level climbs by a smaller fixed step per tick, in the way a capacitor charges from a constant current. The latch clears only when no fault remains and the level has fallen below a low threshold. A short circuit therefore gives repeated shutdown and slow-restart cycles (hiccup recovery). The error code passed to the PWM core never exceeds the soft-start level.

Top module: `softstart_supervisor`

## Requirements
- R1: The supply lockout releases when the registered supply code is strictly above SUP_ON (default 460). It asserts again when the code is strictly below SUP_OFF (default 420). For codes from SUP_OFF to SUP_ON inclusive, its state does not change.
- R2: The reference lockout follows the same rule as R1, with VREF_ON (default 840) and VREF_OFF (default 720).
- R3: `drive_en` is 1 only when both lockouts are released and the restart latch is clear.
- R4: The restart latch sets when either lockout is active or the registered current code is strictly above SHUT_TH (default 700); a code equal to SHUT_TH is not a fault. When a set condition is present, the latch is set whatever the soft-start level is.
- R5: The latch clears only when no set condition is present and the soft-start level is below SS_LOW (default 100). A level at or above SS_LOW holds it set after the fault is gone.
- R6: While the latch is set, each cycle with `ss_tick` high lowers the level by DIS_STEP (default 16), saturating at 0.
- R7: While the latch is clear, each cycle with `ss_tick` high raises the level by CHG_STEP (default 4), saturating at 2^CW-1 (1023).
- R8: `duty_cap` equals the smaller of the registered error code and the soft-start level.
- R9: A synchronous reset puts both lockouts in the active state, sets the latch, zeroes the level and the input registers, and so gives `drive_en`=0 and `duty_cap`=0.
- R10: The soft-start level changes only on cycles where `ss_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_tick | input | 1 | Soft-start rate tick; one level step per high cycle |
| sup_code | input | CW | Digitized supply voltage |
| vref_code | input | CW | Digitized internal reference voltage |
| isen_code | input | CW | Digitized switch-current reading |
| err_code | input | CW | Error code from the control loop |
| drive_en | output | 1 | Output-stage enable for the PWM core |
| duty_cap | output | CW | Error code after the soft-start clamp |

## Verification
Assertions check the following on every cycle:
- the hysteresis rules of each lockout, including that it holds inside the dead band;
- that a set condition always sets the latch;
- that the latch stays set while the level is at or above the low threshold;
- the direction of each level step, and that the level holds when there is no tick;
- that `drive_en` only rises with the level below the low threshold.

Only the bench scenarios show the exact step sizes, saturation at both ends, and the boundary codes that are or are not faults. They also show the full hiccup sequence: the level stays up after the overcurrent is removed, and the block restarts only after enough discharge ticks.

// File: rtl/ssv_pkg.sv
package ssv_pkg;

    // Fault sources that set the restart latch
    typedef struct packed {
        logic sup_low;
        logic vref_low;
        logic overcur;
    } fault_t;

    // Direction of the soft-start level for one cycle
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;

    function automatic logic any_fault(input fault_t f);
        return f.sup_low | f.vref_low | f.overcur;
    endfunction

    // Saturating step of the level, computed on 32-bit values
    function automatic int unsigned ramp_step(input int unsigned lvl,
                                              input int unsigned up_step,
                                              input int unsigned dn_step,
                                              input int unsigned top,
                                              input ramp_dir_e   dir);
        case (dir)
            RAMP_UP:   return (lvl + up_step >= top) ? top : lvl + up_step;
            RAMP_DOWN: return (lvl <= dn_step) ? 0 : lvl - dn_step;
            default:   return lvl;
        endcase
    endfunction

endpackage

// File: rtl/ssv_hyst_lockout.sv
module ssv_hyst_lockout #(
    parameter int CW  = 10,
    parameter int ON  = 460,
    parameter int OFF = 420
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] code,
    output logic          locked
);
    localparam logic [CW-1:0] ON_C  = CW'(ON);
    localparam logic [CW-1:0] OFF_C = CW'(OFF);

    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b1;
        else if (locked && code > ON_C)
            locked <= 1'b0;
        else if (!locked && code < OFF_C)
            locked <= 1'b1;
    end

    // R1 R2
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && code > ON_C) |=> !locked);
    // R1 R2
    trip_chk: assert property (@(posedge clk) disable iff (rst)
        (!locked && code < OFF_C) |=> locked);
    // R1 R2
    deadband_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (code >= OFF_C && code <= ON_C) |=> $stable(locked));

endmodule

// File: rtl/ssv_hiccup_latch.sv
module ssv_hiccup_latch
    import ssv_pkg::*;
#(
    parameter int CW     = 10,
    parameter int SS_LOW = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  fault_t        faults,
    input  logic [CW-1:0] lvl,
    output logic          latched
);
    localparam logic [CW-1:0] LOW_C = CW'(SS_LOW);

    logic set_req;
    logic clr_ok;

    assign set_req = any_fault(faults);
    assign clr_ok  = lvl < LOW_C;

    // Set-dominant: a set request overrides everything
    always_ff @(posedge clk) begin
        if (rst)
            latched <= 1'b1;
        else if (set_req)
            latched <= 1'b1;
        else if (clr_ok)
            latched <= 1'b0;
    end

    // R4
    set_dominant_chk: assert property (@(posedge clk) disable iff (rst)
        set_req |=> latched);
    // R5
    hold_high_level_chk: assert property (@(posedge clk) disable iff (rst)
        (latched && lvl >= LOW_C) |=> latched);

endmodule

// File: rtl/ssv_ss_ramp.sv
module ssv_ss_ramp
    import ssv_pkg::*;
#(
    parameter int CW  = 10,
    parameter int CHG = 4,
    parameter int DIS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          latched,
    output logic [CW-1:0] lvl
);
    localparam int unsigned TOP = (1 << CW) - 1;

    ramp_dir_e dir;
    logic [CW-1:0] lvl_nxt;

    always_comb begin
        if (!tick)
            dir = RAMP_HOLD;
        else if (latched)
            dir = RAMP_DOWN;
        else
            dir = RAMP_UP;
        lvl_nxt = CW'(ramp_step(32'(lvl), CHG, DIS, TOP, dir));
    end

    always_ff @(posedge clk) begin
        if (rst)
            lvl <= '0;
        else
            lvl <= lvl_nxt;
    end

    // R6
    discharge_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && latched) |=> lvl <= $past(lvl));
    // R7
    charge_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !latched) |=> lvl >= $past(lvl));
    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(lvl));

endmodule

// File: rtl/softstart_supervisor.sv
module softstart_supervisor
    import ssv_pkg::*;
#(
    parameter int CW       = 10,
    parameter int SUP_ON   = 460,
    parameter int SUP_OFF  = 420,
    parameter int VREF_ON  = 840,
    parameter int VREF_OFF = 720,
    parameter int SHUT_TH  = 700,
    parameter int SS_LOW   = 100,
    parameter int CHG_STEP = 4,
    parameter int DIS_STEP = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ss_tick,
    input  logic [CW-1:0] sup_code,
    input  logic [CW-1:0] vref_code,
    input  logic [CW-1:0] isen_code,
    input  logic [CW-1:0] err_code,
    output logic          drive_en,
    output logic [CW-1:0] duty_cap
);
    localparam logic [CW-1:0] SHUT_C = CW'(SHUT_TH);
    localparam logic [CW-1:0] LOW_C  = CW'(SS_LOW);

    logic [CW-1:0] sup_q, vref_q, isen_q, err_q;
    logic          sup_lock, vref_lock, latched;
    logic [CW-1:0] ss_lvl;
    fault_t        faults;

    // Input registers in front of every comparator
    always_ff @(posedge clk) begin
        if (rst) begin
            sup_q  <= '0;
            vref_q <= '0;
            isen_q <= '0;
            err_q  <= '0;
        end else begin
            sup_q  <= sup_code;
            vref_q <= vref_code;
            isen_q <= isen_code;
            err_q  <= err_code;
        end
    end

    ssv_hyst_lockout #(.CW(CW), .ON(SUP_ON), .OFF(SUP_OFF)) u_sup_lock (
        .clk(clk), .rst(rst), .code(sup_q), .locked(sup_lock));

    ssv_hyst_lockout #(.CW(CW), .ON(VREF_ON), .OFF(VREF_OFF)) u_vref_lock (
        .clk(clk), .rst(rst), .code(vref_q), .locked(vref_lock));

    always_comb begin
        faults.sup_low  = sup_lock;
        faults.vref_low = vref_lock;
        faults.overcur  = isen_q > SHUT_C;
    end

    ssv_hiccup_latch #(.CW(CW), .SS_LOW(SS_LOW)) u_latch (
        .clk(clk), .rst(rst), .faults(faults), .lvl(ss_lvl), .latched(latched));

    ssv_ss_ramp #(.CW(CW), .CHG(CHG_STEP), .DIS(DIS_STEP)) u_ramp (
        .clk(clk), .rst(rst), .tick(ss_tick), .latched(latched), .lvl(ss_lvl));

    assign drive_en = !(sup_lock || vref_lock || latched);
    assign duty_cap = (err_q < ss_lvl) ? err_q : ss_lvl;

    // R5
    enable_low_level_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en) |-> ss_lvl < LOW_C);
    // R8
    cap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (duty_cap <= err_q) && (duty_cap <= ss_lvl));

endmodule

// File: tb/softstart_supervisor_test.sv
module softstart_supervisor_test;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ss_tick = 1'b0;
    logic [CW-1:0] sup_code = '0, vref_code = '0, isen_code = '0, err_code = '0;
    logic          drive_en;
    logic [CW-1:0] duty_cap;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    softstart_supervisor uut (
        .clk(clk), .rst(rst), .ss_tick(ss_tick),
        .sup_code(sup_code), .vref_code(vref_code),
        .isen_code(isen_code), .err_code(err_code),
        .drive_en(drive_en), .duty_cap(duty_cap));

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung, expected run to finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        ss_tick = 1'b1;
        wait_n(n);
        ss_tick = 1'b0;
    endtask

    task automatic t_reset();
        err_code = 10'd1023;
        wait_n(3);
        chk("R9 drive_en in reset", drive_en, 0);
        chk("R9 duty_cap in reset", duty_cap, 0);
        rst = 1'b0;
        wait_n(1);
    endtask

    task automatic t_powerup();
        sup_code = 10'd470;
        wait_n(5);
        chk("R3 supply only, drive off", drive_en, 0);
        vref_code = 10'd850;
        wait_n(5);
        chk("R3 R5 both released, latch cleared", drive_en, 1);
        chk("R10 level still zero without tick", duty_cap, 0);
    endtask

    task automatic t_ramp_and_clamp();
        ticks(10);
        wait_n(3);
        chk("R7 level after 10 ticks", duty_cap, 40);
        wait_n(20);
        chk("R10 level held without tick", duty_cap, 40);
        err_code = 10'd25;
        wait_n(2);
        chk("R8 clamp picks error code", duty_cap, 25);
        err_code = 10'd1023;
        wait_n(2);
    endtask

    task automatic t_supply_hyst();
        sup_code = 10'd430;
        wait_n(5);
        chk("R1 dead band keeps released", drive_en, 1);
        sup_code = 10'd419;
        wait_n(4);
        chk("R1 trip below off code", drive_en, 0);
        ticks(1);
        wait_n(2);
        chk("R6 one discharge step", duty_cap, 24);
        sup_code = 10'd440;
        wait_n(4);
        chk("R1 dead band keeps lockout", drive_en, 0);
        ticks(3);
        wait_n(2);
        chk("R6 discharge saturates at zero", duty_cap, 0);
        sup_code = 10'd460;
        wait_n(5);
        chk("R1 code equal to on code stays locked", drive_en, 0);
        sup_code = 10'd461;
        wait_n(5);
        chk("R1 release above on code", drive_en, 1);
    endtask

    task automatic t_vref_hyst();
        vref_code = 10'd730;
        wait_n(5);
        chk("R2 dead band keeps released", drive_en, 1);
        vref_code = 10'd719;
        wait_n(4);
        chk("R2 trip below off code", drive_en, 0);
        vref_code = 10'd841;
        wait_n(5);
        chk("R2 release above on code", drive_en, 1);
    endtask

    task automatic t_hiccup();
        isen_code = 10'd700;
        wait_n(4);
        chk("R4 current equal to threshold not a fault", drive_en, 1);
        ticks(40);
        wait_n(2);
        chk("R7 level after 40 ticks", duty_cap, 160);
        isen_code = 10'd701;
        wait_n(3);
        isen_code = 10'd0;
        wait_n(4);
        chk("R4 overcurrent sets latch", drive_en, 0);
        wait_n(10);
        chk("R5 high level holds latch", drive_en, 0);
        ticks(3);
        wait_n(3);
        chk("R5 level 112 still holds latch", drive_en, 0);
        chk("R6 three discharge steps", duty_cap, 112);
        ticks(1);
        wait_n(4);
        chk("R5 release below low level", drive_en, 1);
        chk("R6 level after fourth step", duty_cap, 96);
        isen_code = 10'd750;
        wait_n(4);
        ticks(10);
        wait_n(2);
        chk("R4 set dominates at low level", drive_en, 0);
        chk("R6 level at zero", duty_cap, 0);
        isen_code = 10'd0;
        wait_n(5);
        chk("R5 restart after fault removed", drive_en, 1);
    endtask

    task automatic t_saturate();
        ticks(300);
        wait_n(2);
        chk("R7 charge saturates at full scale", duty_cap, 1023);
        err_code = 10'd500;
        wait_n(2);
        chk("R8 clamp with full level", duty_cap, 500);
        err_code = 10'd0;
        wait_n(2);
        chk("R8 zero error code", duty_cap, 0);
    endtask

    task automatic t_rereset();
        err_code = 10'd1023;
        rst = 1'b1;
        wait_n(2);
        chk("R9 drive_en after mid-run reset", drive_en, 0);
        chk("R9 level cleared by reset", duty_cap, 0);
        rst = 1'b0;
        wait_n(8);
        chk("R9 R3 restart after reset", drive_en, 1);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_ramp_and_clamp();
        t_supply_hyst();
        t_vref_hyst();
        t_hiccup();
        t_saturate();
        t_rereset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule